// File: doc/BRIEF.md
# External Interrupt Line Controller

The block gathers a parameterized set of external interrupt lines (64 by default, grouped 32 to a register word) and folds them into one interrupt request for a processor. Every line passes through a two-flop synchronizer. Software then chooses, per line, whether the line fires on a level or on an edge, and whether the active sense is high/rising or low/falling. Edge events are latched in a status bit until software acknowledges them. Level lines report their current active state directly.

Software can also inject a pending interrupt on any line through a pair of soft-trigger aliases. A line reaches the combined output only when it is unmasked and its domain-enable bit is set. Each per-line control field is changed through SET and CLR aliases, so a write alters only the bits written as 1, and no read-modify-write is needed. The register bus is a plain single-cycle bus. Writes take effect at the clock edge where the write enable is sampled. Reads are combinational from the read address.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every mask bit and every polarity bit reads 1, and sensitivity, domain-enable, status and soft-pending read 0. The interrupt output is low.
- R2: A write to a SET alias sets exactly the bits written as 1. A write to a CLR alias clears exactly those bits. All other bits keep their values.
- R3: The address is {group[3:0], word}. Line n sits at bit n mod 32 of word n/32. The group codes are: 0/1/2 mask read/set/clr, 3/4/5 polarity, 6/7/8 sensitivity, 9/10/11 domain-enable, 12 status read, 13 acknowledge, 14/15 soft set/clr. Reads of 14 or 15 return soft-pending, and a read of 13 returns status.
- R4: With sensitivity 0 (edge) and polarity 1, a low-to-high transition of the line sets its status bit. The bit stays set after the line returns low.
- R5: With sensitivity 0 and polarity 0, a high-to-low transition sets status, and a low-to-high transition does not.
- R6: With sensitivity 1 (level), the status bit follows the active level of the synchronized line (high when polarity is 1, low when polarity is 0). Acknowledge has no effect on it.
- R7: Writing 1 to a line's acknowledge bit clears that line's latched edge status. Bits written 0 leave status unchanged.
- R8: When an acknowledge and a new active edge on the same line meet in one clock, the status bit stays set.
- R9: The soft set alias makes a line pending and the soft clr alias removes it. Soft-pending drives the output without touching the status bit.
- R10: The output is the OR over all lines of (status or soft-pending) and not mask and domain-enable. A masked line or a line with domain-enable 0 never raises it.
- R11: Changing a line's polarity while its input is stable does not latch status.
- R12: A line change on the input appears in status three clock edges later: two synchronizer stages and then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NLINES | Asynchronous external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address {group, word} |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address {group, word} |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An acknowledge write and a freshly synchronized active edge can meet in the same clock, and the edge must win. The bench raises the line, waits one cycle, and then issues the acknowledge so that its write edge is the very edge where the new event is registered. It then reads status back and expects the bit still set. The reverse order, with the acknowledge a cycle after the edge has already been latched, is judged separately and must clear the bit.

// File: rtl/extint_pkg.sv
// Shared definitions for the external interrupt controller.
// Assumes 32-bit register words; the group code sits above the word index.
package extint_pkg;
    localparam int WORD_BITS = 32;
    localparam int GRP_BITS  = 4;

    typedef enum logic [GRP_BITS-1:0] {
        GRP_MASK     = 4'd0,
        GRP_MASK_SET = 4'd1,
        GRP_MASK_CLR = 4'd2,
        GRP_POL      = 4'd3,
        GRP_POL_SET  = 4'd4,
        GRP_POL_CLR  = 4'd5,
        GRP_SENS     = 4'd6,
        GRP_SENS_SET = 4'd7,
        GRP_SENS_CLR = 4'd8,
        GRP_DOM      = 4'd9,
        GRP_DOM_SET  = 4'd10,
        GRP_DOM_CLR  = 4'd11,
        GRP_STAT     = 4'd12,
        GRP_ACK      = 4'd13,
        GRP_SOFT_SET = 4'd14,
        GRP_SOFT_CLR = 4'd15
    } grp_e;
endpackage

// File: rtl/extint_sync.sv
// Two-flop synchronizer for a vector of asynchronous lines.
// Assumes each bit is independent; no multi-bit coherence is required.
module extint_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Purpose: carry each line through two flops before use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/extint_regfile.sv
// Per-line control registers with SET/CLR aliases, soft-pending bits,
// acknowledge decode and combinational read mux.
// Assumes NLINES is a multiple of 32 and address = {group, word}.
module extint_regfile
    import extint_pkg::*;
#(
    parameter int NLINES = 64,
    parameter int WORD_W = 1,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NLINES-1:0] status_q,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] pol_q,
    output logic [NLINES-1:0] sens_q,
    output logic [NLINES-1:0] dom_q,
    output logic [NLINES-1:0] soft_q,
    output logic [NLINES-1:0] ack_vec,
    output logic [NLINES-1:0] soft_set_vec,
    output logic [NLINES-1:0] soft_clr_vec
);
    localparam int NWORDS = NLINES / WORD_BITS;

    grp_e              wr_grp;
    grp_e              rd_grp;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic [NLINES-1:0] wslot;
    logic [NLINES-1:0] rd_vec;
    logic [NLINES-1:0] mask_set, mask_clr, pol_set, pol_clr;
    logic [NLINES-1:0] sens_set, sens_clr, dom_set, dom_clr;

    assign wr_grp  = grp_e'(wr_addr[ADDR_W-1:WORD_W]);
    assign rd_grp  = grp_e'(rd_addr[ADDR_W-1:WORD_W]);
    assign wr_word = wr_addr[WORD_W-1:0];
    assign rd_word = rd_addr[WORD_W-1:0];

    // Purpose: place write data in the addressed word slot of a line-wide vector.
    always_comb begin
        wslot = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (wr_en && (wr_word == WORD_W'(w)))
                wslot[w*WORD_BITS +: WORD_BITS] = wr_data;
        end
    end

    assign mask_set     = (wr_grp == GRP_MASK_SET) ? wslot : '0;
    assign mask_clr     = (wr_grp == GRP_MASK_CLR) ? wslot : '0;
    assign pol_set      = (wr_grp == GRP_POL_SET)  ? wslot : '0;
    assign pol_clr      = (wr_grp == GRP_POL_CLR)  ? wslot : '0;
    assign sens_set     = (wr_grp == GRP_SENS_SET) ? wslot : '0;
    assign sens_clr     = (wr_grp == GRP_SENS_CLR) ? wslot : '0;
    assign dom_set      = (wr_grp == GRP_DOM_SET)  ? wslot : '0;
    assign dom_clr      = (wr_grp == GRP_DOM_CLR)  ? wslot : '0;
    assign ack_vec      = (wr_grp == GRP_ACK)      ? wslot : '0;
    assign soft_set_vec = (wr_grp == GRP_SOFT_SET) ? wslot : '0;
    assign soft_clr_vec = (wr_grp == GRP_SOFT_CLR) ? wslot : '0;

    // Purpose: update control bits from their SET and CLR aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '1;
            sens_q <= '0;
            dom_q  <= '0;
            soft_q <= '0;
        end else begin
            mask_q <= (mask_q | mask_set)     & ~mask_clr;
            pol_q  <= (pol_q  | pol_set)      & ~pol_clr;
            sens_q <= (sens_q | sens_set)     & ~sens_clr;
            dom_q  <= (dom_q  | dom_set)      & ~dom_clr;
            soft_q <= (soft_q | soft_set_vec) & ~soft_clr_vec;
        end
    end

    // Purpose: choose the line-wide vector for the read group.
    always_comb begin
        unique case (rd_grp)
            GRP_MASK, GRP_MASK_SET, GRP_MASK_CLR: rd_vec = mask_q;
            GRP_POL,  GRP_POL_SET,  GRP_POL_CLR:  rd_vec = pol_q;
            GRP_SENS, GRP_SENS_SET, GRP_SENS_CLR: rd_vec = sens_q;
            GRP_DOM,  GRP_DOM_SET,  GRP_DOM_CLR:  rd_vec = dom_q;
            GRP_STAT, GRP_ACK:                    rd_vec = status_q;
            default:                              rd_vec = soft_q;
        endcase
    end

    // Purpose: slice the addressed word out of the selected vector.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (rd_word == WORD_W'(w))
                rd_data = rd_vec[w*WORD_BITS +: WORD_BITS];
        end
    end
endmodule

// File: rtl/extint_detect.sv
// Per-line event detection: edge latching with acknowledge, or level tracking.
// Assumes inputs are already synchronized; edges are judged on the raw
// synchronized value so a polarity change alone creates no event.
module extint_detect #(
    parameter int NLINES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_s,
    input  logic [NLINES-1:0] pol_q,
    input  logic [NLINES-1:0] sens_q,
    input  logic [NLINES-1:0] ack_vec,
    output logic [NLINES-1:0] act_vec,
    output logic [NLINES-1:0] edge_vec,
    output logic [NLINES-1:0] status_q
);
    logic [NLINES-1:0] line_d;

    // Purpose: hold the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= '0;
        else        line_d <= line_s;
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign act_vec[i]  = pol_q[i] ? line_s[i] : ~line_s[i];
        assign edge_vec[i] = pol_q[i] ? (line_s[i] & ~line_d[i])
                                      : (~line_s[i] & line_d[i]);

        // Purpose: track level or latch edge, new edge winning over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)          status_q[i] <= 1'b0;
            else if (sens_q[i])  status_q[i] <= act_vec[i];
            else if (edge_vec[i]) status_q[i] <= 1'b1;
            else if (ack_vec[i]) status_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/extint_ctrl.sv
// Top of the external interrupt controller: synchronizer, register file,
// event detection and the combined interrupt output.
// Assumes NLINES is a multiple of 32.
module extint_ctrl #(
    parameter int NLINES = 64,
    localparam int NWORDS = NLINES / 32,
    localparam int WORD_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int ADDR_W = 4 + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_out
);
    logic [NLINES-1:0] line_s;
    logic [NLINES-1:0] mask_q, pol_q, sens_q, dom_q, soft_q;
    logic [NLINES-1:0] ack_vec, soft_set_vec, soft_clr_vec;
    logic [NLINES-1:0] act_vec, edge_vec, status_q;

    extint_sync #(.WIDTH(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(line_s)
    );

    extint_regfile #(.NLINES(NLINES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .status_q(status_q),
        .mask_q(mask_q), .pol_q(pol_q), .sens_q(sens_q), .dom_q(dom_q),
        .soft_q(soft_q), .ack_vec(ack_vec),
        .soft_set_vec(soft_set_vec), .soft_clr_vec(soft_clr_vec)
    );

    extint_detect #(.NLINES(NLINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .pol_q(pol_q), .sens_q(sens_q), .ack_vec(ack_vec),
        .act_vec(act_vec), .edge_vec(edge_vec), .status_q(status_q)
    );

    // Purpose: fold every enabled, unmasked pending line into one request.
    assign irq_out = |((status_q | soft_q) & ~mask_q & dom_q);
endmodule

// File: rtl/extint_ctrl_chk.sv
// Property checker for the external interrupt controller, bound to the top.
module extint_ctrl_chk #(
    parameter int NLINES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_out,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] dom_q,
    input logic [NLINES-1:0] sens_q,
    input logic [NLINES-1:0] status_q,
    input logic [NLINES-1:0] soft_q,
    input logic [NLINES-1:0] ack_vec,
    input logic [NLINES-1:0] edge_vec,
    input logic [NLINES-1:0] act_vec,
    input logic [NLINES-1:0] soft_clr_vec
);
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_vec & ~sens_q) & ~status_q) == '0));

    p_level_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_q ^ $past(act_vec)) & $past(sens_q)) == '0));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(ack_vec & ~sens_q & ~edge_vec)) == '0));

    p_soft_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((soft_q & $past(soft_clr_vec)) == '0));

    p_dom_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_q == '0) |-> !irq_out);

    p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_out);
endmodule

bind extint_ctrl extint_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out),
    .mask_q(mask_q), .dom_q(dom_q), .sens_q(sens_q),
    .status_q(status_q), .soft_q(soft_q), .ack_vec(ack_vec),
    .edge_vec(edge_vec), .act_vec(act_vec), .soft_clr_vec(soft_clr_vec)
);

// File: tb/extint_ctrl_bench.sv
`timescale 1ns/10ps
module extint_ctrl_bench;
    localparam int NL = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit busy     = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [4:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    extint_ctrl #(.NLINES(NL)) u_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    function automatic logic [4:0] ad(int grp, int word);
        return {grp[3:0], word[0]};
    endfunction

    // Driver side: register write at a falling edge.
    task automatic wr(int grp, int word, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad(grp, word); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic drive(int line, logic v);
        @(negedge clk);
        irq_in[line] = v;
        #1;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic push(bit is_irq, logic [4:0] a, logic [31:0] e, string req);
        item_t it;
        it.is_irq = is_irq; it.addr = a; it.exp = e; it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0 && !busy);
    endtask

    task automatic exp_rd(int grp, int word, logic [31:0] e, string req);
        push(1'b0, ad(grp, word), e, req);
    endtask

    task automatic exp_irq(logic e, string req);
        push(1'b1, 5'd0, {31'd0, e}, req);
    endtask

    // Monitor: pops expected items and compares with the design outputs.
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (sb_q.size() != 0);
            busy = 1'b1;
            it = sb_q.pop_front();
            rd_addr = it.addr;
            #0.1;
            got = it.is_irq ? {31'd0, irq_out} : rd_data;
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
            busy = 1'b0;
        end
    end

    initial begin
        #3000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1 reset state
        exp_rd(0, 0, 32'hFFFF_FFFF, "R1 mask w0");
        exp_rd(0, 1, 32'hFFFF_FFFF, "R1 mask w1");
        exp_rd(3, 0, 32'hFFFF_FFFF, "R1 pol w0");
        exp_rd(6, 1, 32'h0, "R1 sens w1");
        exp_rd(9, 0, 32'h0, "R1 dom w0");
        exp_rd(12, 0, 32'h0, "R1 status w0");
        exp_rd(14, 1, 32'h0, "R1 soft w1");
        exp_irq(1'b0, "R1 irq");

        // R2 aliases
        wr(10, 0, 32'hFFFF_FFFF);
        wr(10, 1, 32'hFFFF_FFFF);
        wr(2, 0, 32'h0000_0008);
        exp_rd(0, 0, 32'hFFFF_FFF7, "R2 mask clr one bit");
        exp_rd(1, 1, 32'hFFFF_FFFF, "R2 other word untouched");
        exp_rd(11, 0, 32'hFFFF_FFFF, "R2 dom set");

        // R12 and R4: rising edge on line 3
        drive(3, 1'b1);
        step(2);
        exp_rd(12, 0, 32'h0, "R12 not yet after two edges");
        step(1);
        exp_rd(12, 0, 32'h0000_0008, "R12 R4 latched after three edges");
        exp_irq(1'b1, "R4 irq raised");
        drive(3, 1'b0);
        step(3);
        exp_rd(12, 0, 32'h0000_0008, "R4 held after line drops");

        // R7 acknowledge
        wr(13, 0, 32'h0000_0010);
        exp_rd(12, 0, 32'h0000_0008, "R7 ack of other bit");
        wr(13, 0, 32'h0000_0008);
        exp_rd(12, 0, 32'h0, "R7 ack clears");
        exp_irq(1'b0, "R7 irq cleared");

        // R3 mapping: line 37 -> word 1 bit 5
        wr(2, 1, 32'h0000_0020);
        drive(37, 1'b1);
        step(3);
        exp_rd(12, 1, 32'h0000_0020, "R3 line37 word1 bit5");
        exp_rd(13, 0, 32'h0, "R3 word0 untouched");
        exp_irq(1'b1, "R3 irq");
        wr(13, 1, 32'h0000_0020);
        drive(37, 1'b0);
        step(3);
        exp_rd(12, 1, 32'h0, "R3 cleared");

        // R11 polarity change alone
        wr(5, 0, 32'h0000_0008);
        step(3);
        exp_rd(12, 0, 32'h0, "R11 pol change no event");
        exp_rd(3, 0, 32'hFFFF_FFF7, "R2 pol clr");

        // R5 falling sense
        drive(3, 1'b1);
        step(3);
        exp_rd(12, 0, 32'h0, "R5 rising ignored");
        drive(3, 1'b0);
        step(3);
        exp_rd(12, 0, 32'h0000_0008, "R5 falling latched");
        wr(13, 0, 32'h0000_0008);

        // R6 level, active low
        wr(7, 0, 32'h0000_0008);
        step(1);
        exp_rd(12, 0, 32'h0000_0008, "R6 level active");
        exp_irq(1'b1, "R6 irq level");
        wr(13, 0, 32'h0000_0008);
        exp_rd(12, 0, 32'h0000_0008, "R6 ack ignored");
        drive(3, 1'b1);
        step(3);
        exp_rd(12, 0, 32'h0, "R6 follows inactive");
        exp_irq(1'b0, "R6 irq drops");
        wr(8, 0, 32'h0000_0008);
        wr(4, 0, 32'h0000_0008);
        drive(3, 1'b0);
        step(3);
        exp_rd(12, 0, 32'h0, "R4 falling ignored with pol 1");

        // R8 ack and edge in one clock
        drive(3, 1'b1);
        step(1);
        wr(13, 0, 32'h0000_0008);
        exp_rd(12, 0, 32'h0000_0008, "R8 edge wins over ack");
        wr(13, 0, 32'h0000_0008);
        exp_rd(12, 0, 32'h0, "R7 later ack clears");

        // R9 soft trigger on line 40
        wr(2, 1, 32'h0000_0100);
        wr(14, 1, 32'h0000_0100);
        exp_irq(1'b1, "R9 soft raises irq");
        exp_rd(15, 1, 32'h0000_0100, "R9 soft readback");
        exp_rd(12, 1, 32'h0, "R9 status untouched");
        wr(15, 1, 32'h0000_0100);
        exp_irq(1'b0, "R9 soft cleared");
        exp_rd(14, 1, 32'h0, "R9 soft readback cleared");

        // R10 gating
        wr(14, 1, 32'h0000_0100);
        wr(1, 1, 32'h0000_0100);
        exp_irq(1'b0, "R10 mask blocks");
        wr(2, 1, 32'h0000_0100);
        exp_irq(1'b1, "R10 unmasked");
        wr(11, 1, 32'h0000_0100);
        exp_rd(9, 1, 32'hFFFF_FEFF, "R10 dom clr");
        exp_irq(1'b0, "R10 domain blocks");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule